// File: doc/BRIEF.md
# Dual-Image Boot Fallback Sequencer

This block decides which of two stored configuration images a device loads, and it tracks each load through to user mode. At power-up it takes the image from an external select pin. On later reconfigurations a software override can pick the image instead. The image loader is outside the block. The block asks for a load with `load_req` and `img_sel`, and the loader answers with `load_done` or `load_err`.

When the first image fails, the sequencer switches once to the other image. A failure is a CRC error, either reported by the loader or flagged in user mode, or a user watchdog timeout. If a second failure follows, the sequencer stops and waits for a reconfiguration request. When auto-restart is enabled it starts a new load at once instead. A 4-bit state code tells a normal load apart from a post-revert load. Each time a configuration ends, a 32-bit record stores the winning cause and the state code at that moment. The record before it moves into a second history slot.

Top module: `bfs_boot_seq`

## Requirements
- R1: While `rst_n` is low, `load_req` is 0, `state_code` is 0000 and both records are 0. On the first clock edge after reset release, a load of the image named by `sel_pin` starts. `load_req` then stays 1 until `load_done` or an event ends the load. A `load_done` moves the block to user mode with `load_req` 0.
- R2: The first load after reset always uses `sel_pin`. Every later normal load uses `ovr_img` when `ovr_en` is 1, and `sel_pin` otherwise.
- R3: State codes are 0010 for image 0 normal, 0100 for image 1 normal, 0011 for image 1 after revert and 0101 for image 0 after revert. On the first error with fallback enabled, the block loads the other image and shows the matching revert code.
- R4: If an error occurs when one error has already been seen and `auto_restart` is 0, the block waits with `load_req` 0 and `state_code` 0000. It then starts a normal load on the next reconfiguration request.
- R5: If the same second error occurs with `auto_restart` 1, a normal load starts on the same edge. No request is needed.
- R6: With `auto_fallback` 0, every load uses image 0, and `sel_pin` and the override are ignored. An error never switches to image 1. It behaves as a second error (R4/R5).
- R7: The record has one-hot cause bits: external configuration request at bit 31, CRC error at bit 30, external status request at bit 29, watchdog timeout at bit 28 and internal request at bit 27. The state code at the event sits in bits 25:22, and all other bits are 0. When causes coincide, only the highest bit is kept, and that cause alone decides the action.
- R8: Each time a new record is written, the previous record moves to `prev_rec_old`.
- R9: A reconfiguration request taken in user mode clears the error history. The next error after that reverts again instead of waiting.
- R10: The three request inputs are active low and act only on a falling edge. Holding one low does not trigger again. A request taken during the wait state starts a load but writes no record.
- R11: `crc_err` and `wdog_to` are ignored unless the block is in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sel_pin | input | 1 | External image select |
| ovr_en | input | 1 | Override enable (upgrade register bit 12) |
| ovr_img | input | 1 | Override image (upgrade register bit 13) |
| auto_fallback | input | 1 | Enable revert to the other image |
| auto_restart | input | 1 | Reload at once after a second error |
| crc_err | input | 1 | CRC error strobe in user mode |
| wdog_to | input | 1 | User watchdog timeout strobe |
| ext_config_n | input | 1 | External reconfiguration request, active low |
| ext_status_n | input | 1 | External status request, active low |
| int_config_n | input | 1 | Internal reconfiguration request, active low |
| load_done | input | 1 | Loader finished successfully |
| load_err | input | 1 | Loader reports CRC failure |
| load_req | output | 1 | Load request to the loader |
| img_sel | output | 1 | Image index to load |
| state_code | output | 4 | Current load state code |
| prev_rec | output | 32 | Most recent end-of-configuration record |
| prev_rec_old | output | 32 | Record before the most recent |

## Verification
The error history and the revert flag cannot be seen directly, so a wrong value shows up only at the next event. A stale error count makes a revert go to the wait state instead (`load_req` low, code 0000). A missed clear, or a wrong revert flag, gives the wrong code on the very edge that follows the event. A priority or edge-detect fault shows up one edge after the stimulus, as a wrong cause bit in `prev_rec` or as an unexpected new load. The directed tasks therefore check every output one cycle after each event, and they chain events so that hidden history is exercised.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int CODE_W  = 4;
  localparam int CAUSE_W = 5;
  localparam int REC_W   = 32;
  localparam int CODE_LO = 22;

  // cause vector index: higher index wins a tie
  localparam int C_CFG = 4;
  localparam int C_CRC = 3;
  localparam int C_STS = 2;
  localparam int C_WDT = 1;
  localparam int C_INT = 0;

  typedef enum logic [1:0] {ST_BOOT, ST_LOAD, ST_USER, ST_WAIT} seq_st_t;

  function automatic logic [CODE_W-1:0] state_code_f(input logic img, input logic rev);
    if (rev) return img ? 4'b0011 : 4'b0101;
    else     return img ? 4'b0100 : 4'b0010;
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_pick_f(input logic [CAUSE_W-1:0] v);
    logic [CAUSE_W-1:0] r;
    r = '0;
    for (int i = 0; i < CAUSE_W; i++)
      if (v[i]) r = CAUSE_W'(1) << i;
    return r;
  endfunction

  function automatic logic [REC_W-1:0] make_rec_f(input logic [CAUSE_W-1:0] c,
                                                  input logic [CODE_W-1:0] code);
    logic [REC_W-1:0] r;
    r = '0;
    r[REC_W-1 -: CAUSE_W] = c;
    r[CODE_LO +: CODE_W]  = code;
    return r;
  endfunction
endpackage

// File: rtl/bfs_edge_det.sv
module bfs_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] last_q;
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q[i] <= 1'b1;
      else        last_q[i] <= in_n[i];
    end
    assign fall[i] = last_q[i] & ~in_n[i];
  end
endmodule

// File: rtl/bfs_img_pick.sv
module bfs_img_pick (
  input  logic fb_en,
  input  logic booted,
  input  logic sel_pin,
  input  logic ovr_en,
  input  logic ovr_img,
  output logic img
);
  always_comb begin
    if (!fb_en)                img = 1'b0;
    else if (booted && ovr_en) img = ovr_img;
    else                       img = sel_pin;
  end
endmodule

// File: rtl/bfs_cause_rec.sv
module bfs_cause_rec
  import bfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REC_W-1:0] rec_in,
  output logic [REC_W-1:0] rec_new,
  output logic [REC_W-1:0] rec_old
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_new <= '0;
      rec_old <= '0;
    end else if (we) begin
      rec_old <= rec_new;
      rec_new <= rec_in;
    end
  end

  p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rec_new[REC_W-1 -: CAUSE_W]));
  p_hist_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_new) |-> rec_old == $past(rec_new));
endmodule

// File: rtl/bfs_boot_seq.sv
module bfs_boot_seq
  import bfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_pin,
  input  logic              ovr_en,
  input  logic              ovr_img,
  input  logic              auto_fallback,
  input  logic              auto_restart,
  input  logic              crc_err,
  input  logic              wdog_to,
  input  logic              ext_config_n,
  input  logic              ext_status_n,
  input  logic              int_config_n,
  input  logic              load_done,
  input  logic              load_err,
  output logic              load_req,
  output logic              img_sel,
  output logic [CODE_W-1:0] state_code,
  output logic [REC_W-1:0]  prev_rec,
  output logic [REC_W-1:0]  prev_rec_old
);
  seq_st_t            st_q;
  logic               img_q, rev_q, booted_q, err_seen_q;
  logic [CODE_W-1:0]  code_q;
  logic [2:0]         fall;
  logic               pick_img;
  logic [CAUSE_W-1:0] raw_cause, win_cause;
  logic               src_ev, err_ev, rec_we;
  logic               go_norm, go_rev, go_wait, start_load;

  bfs_edge_det #(.N(3)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .in_n({ext_config_n, ext_status_n, int_config_n}),
    .fall(fall)
  );

  bfs_img_pick u_pick (
    .fb_en(auto_fallback), .booted(booted_q), .sel_pin(sel_pin),
    .ovr_en(ovr_en), .ovr_img(ovr_img), .img(pick_img)
  );

  // event detection
  logic in_load, in_user, srcs_live;
  assign in_load   = (st_q == ST_LOAD);
  assign in_user   = (st_q == ST_USER);
  assign srcs_live = (st_q != ST_BOOT);

  always_comb begin
    raw_cause        = '0;
    raw_cause[C_CFG] = srcs_live & fall[2];
    raw_cause[C_STS] = srcs_live & fall[1];
    raw_cause[C_INT] = srcs_live & fall[0];
    raw_cause[C_CRC] = (in_load & load_err) | (in_user & crc_err);
    raw_cause[C_WDT] = in_user & wdog_to;
  end

  assign win_cause = cause_pick_f(raw_cause);
  assign src_ev    = win_cause[C_CFG] | win_cause[C_STS] | win_cause[C_INT];
  assign err_ev    = win_cause[C_CRC] | win_cause[C_WDT];
  assign rec_we    = (in_load | in_user) & (src_ev | err_ev);

  // action decode
  assign go_rev     = err_ev & ~err_seen_q & auto_fallback;
  assign go_norm    = (st_q == ST_BOOT) | src_ev | (err_ev & ~go_rev & auto_restart);
  assign go_wait    = err_ev & ~go_rev & ~auto_restart;
  assign start_load = go_norm | go_rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_BOOT;
      img_q      <= 1'b0;
      rev_q      <= 1'b0;
      booted_q   <= 1'b0;
      err_seen_q <= 1'b0;
      code_q     <= '0;
    end else if (go_norm) begin
      st_q     <= ST_LOAD;
      img_q    <= pick_img;
      rev_q    <= 1'b0;
      booted_q <= 1'b1;
      code_q   <= state_code_f(pick_img, 1'b0);
      if (!in_load) err_seen_q <= 1'b0;
    end else if (go_rev) begin
      st_q       <= ST_LOAD;
      img_q      <= ~img_q;
      rev_q      <= 1'b1;
      err_seen_q <= 1'b1;
      code_q     <= state_code_f(~img_q, 1'b1);
    end else if (go_wait) begin
      st_q       <= ST_WAIT;
      err_seen_q <= 1'b1;
      code_q     <= '0;
    end else if (in_load && load_done) begin
      st_q <= ST_USER;
    end
  end

  bfs_cause_rec u_rec (
    .clk(clk), .rst_n(rst_n), .we(rec_we),
    .rec_in(make_rec_f(win_cause, code_q)),
    .rec_new(prev_rec), .rec_old(prev_rec_old)
  );

  assign load_req   = in_load;
  assign img_sel    = img_q;
  assign state_code = code_q;

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_code inside {4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b0101});
  p_img_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> (img_sel ? state_code inside {4'b0011, 4'b0100}
                          : state_code inside {4'b0010, 4'b0101}));
  p_nofb_img0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_load && !auto_fallback |=> !img_sel);
  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_wait |=> !load_req && state_code == 4'b0000);
  p_rev_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_rev |=> img_sel != $past(img_sel));
endmodule

// File: tb/tb_bfs_boot_seq.sv
module tb_bfs_boot_seq;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic sel_pin = 0, ovr_en = 0, ovr_img = 0, auto_fallback = 1, auto_restart = 0;
  logic crc_err = 0, wdog_to = 0, ext_config_n = 1, ext_status_n = 1, int_config_n = 1;
  logic load_done = 0, load_err = 0;
  logic load_req, img_sel;
  logic [3:0] state_code;
  logic [31:0] prev_rec, prev_rec_old;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  bfs_boot_seq dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic lr, logic img, logic [3:0] code);
    chk({req, " load_req"}, 32'(load_req), 32'(lr));
    chk({req, " img_sel"}, 32'(img_sel), 32'(img));
    chk({req, " code"}, 32'(state_code), 32'(code));
  endtask

  function automatic logic [31:0] rec(int cause_bit, logic [3:0] code);
    return (32'h1 << cause_bit) | (32'(code) << 22);
  endfunction

  task automatic boot(logic sel, logic fb, logic rs, logic oe, logic oi);
    rst_n = 0; sel_pin = sel; auto_fallback = fb; auto_restart = rs;
    ovr_en = oe; ovr_img = oi;
    crc_err = 0; wdog_to = 0; load_done = 0; load_err = 0;
    ext_config_n = 1; ext_status_n = 1; int_config_n = 1;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic finish_load();
    load_done = 1; tick(); load_done = 0;
  endtask

  // R1 R3 R4 R8 R10
  task automatic t_revert_then_wait();
    rst_n = 0; tick();
    chk_out("R1 reset", 0, 0, 4'b0000);
    chk("R1 reset rec", prev_rec, 0);
    chk("R1 reset old", prev_rec_old, 0);
    boot(1, 1, 0, 0, 0);
    chk_out("R1 first boot", 1, 1, 4'b0100);
    tick();
    chk("R1 load held", 32'(load_req), 1);
    finish_load();
    chk_out("R1 user mode", 0, 1, 4'b0100);
    crc_err = 1; tick(); crc_err = 0;
    chk_out("R3 revert", 1, 0, 4'b0101);
    chk("R7 crc rec", prev_rec, rec(30, 4'b0100));
    load_err = 1; tick(); load_err = 0;
    chk_out("R4 wait", 0, 0, 4'b0000);
    chk("R7 second rec", prev_rec, rec(30, 4'b0101));
    chk("R8 history", prev_rec_old, rec(30, 4'b0100));
    tick(); tick();
    chk("R4 still waiting", 32'(load_req), 0);
    ext_status_n = 0; tick();
    chk_out("R4 request reload", 1, 1, 4'b0100);
    chk("R10 no rec in wait", prev_rec, rec(30, 4'b0101));
    finish_load(); tick();
    chk("R10 held low no retrigger", 32'(load_req), 0);
    ext_status_n = 1; tick();
    chk("R10 rising ignored", 32'(load_req), 0);
  endtask

  // R2 R9 R5 R7 R8
  task automatic t_override_chain();
    boot(0, 1, 0, 1, 1);
    chk_out("R2 first boot ignores override", 1, 0, 4'b0010);
    finish_load();
    int_config_n = 0; tick(); int_config_n = 1;
    chk_out("R2 override used", 1, 1, 4'b0100);
    chk("R7 internal rec", prev_rec, rec(27, 4'b0010));
    finish_load();
    wdog_to = 1; tick(); wdog_to = 0;
    chk_out("R3 wdog revert", 1, 0, 4'b0101);
    chk("R7 wdog rec", prev_rec, rec(28, 4'b0100));
    finish_load();
    ext_config_n = 0; tick(); ext_config_n = 1;
    chk("R7 cfg rec", prev_rec, rec(31, 4'b0101));
    chk("R8 old rec", prev_rec_old, rec(28, 4'b0100));
    chk_out("R9 reload normal", 1, 1, 4'b0100);
    finish_load();
    crc_err = 1; tick(); crc_err = 0;
    chk_out("R9 cleared, reverts again", 1, 0, 4'b0101);
    auto_restart = 1;
    load_err = 1; tick(); load_err = 0;
    chk_out("R5 auto restart", 1, 1, 4'b0100);
    chk("R5 rec", prev_rec, rec(30, 4'b0101));
    ovr_en = 0; sel_pin = 0;
    finish_load();
    ext_status_n = 0; tick(); ext_status_n = 1;
    chk_out("R2 no override uses pin", 1, 0, 4'b0010);
  endtask

  // R7 tie priority
  task automatic t_ties();
    boot(1, 1, 0, 0, 0);
    finish_load();
    ext_config_n = 0; ext_status_n = 0; crc_err = 1; wdog_to = 1; tick();
    crc_err = 0; wdog_to = 0; ext_config_n = 1; ext_status_n = 1;
    chk("R7 cfg wins tie", prev_rec, rec(31, 4'b0100));
    chk_out("R7 tie acts as request", 1, 1, 4'b0100);
    tick(); finish_load();
    crc_err = 1; wdog_to = 1; tick(); crc_err = 0; wdog_to = 0;
    chk("R7 crc beats wdog", prev_rec, rec(30, 4'b0100));
    chk_out("R7 tie revert", 1, 0, 4'b0101);
  endtask

  // R6 R11
  task automatic t_no_fallback();
    boot(1, 0, 0, 1, 1);
    chk_out("R6 image 0 only", 1, 0, 4'b0010);
    crc_err = 1; wdog_to = 1; tick(); crc_err = 0; wdog_to = 0;
    chk_out("R11 strobes ignored in load", 1, 0, 4'b0010);
    chk("R11 no rec", prev_rec, 0);
    finish_load();
    crc_err = 1; tick(); crc_err = 0;
    chk_out("R6 no fallback waits", 0, 0, 4'b0000);
    chk("R6 rec", prev_rec, rec(30, 4'b0010));
    ext_config_n = 0; tick(); ext_config_n = 1;
    chk_out("R6 reload still image 0", 1, 0, 4'b0010);
    auto_restart = 1; finish_load();
    wdog_to = 1; tick(); wdog_to = 0;
    chk_out("R6 restart image 0", 1, 0, 4'b0010);
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_revert_then_wait();
    t_override_chain();
    t_ties();
    t_no_fallback();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule